// File: doc/BRIEF.md
# Load-Shadow Issue Queue Retire Control

This block decides, for every slot of a small floating-point issue queue, the cycle in which the slot's instruction leaves the queue. The queue issues instructions while the result of a floating-point load is still speculative. An instruction issued in the single cycle after a load issues is in that load's shadow. The block records two facts for each slot: whether its instruction was issued in a shadow, and whether that instruction consumes the shadowing load's data.

A slot normally leaves the queue four cycles after its issue cycle. A dependent instruction in a shadow waits one extra cycle if the load hits. If the load misses, the instruction is aborted in its normal removal cycle and starts requesting issue again at once. An independent instruction in a shadow ignores the load's outcome.

Slot allocation, issue selection, the dependency flag and the load outcome all come from neighbouring logic as plain inputs. The hit/miss input is sampled in one fixed cycle after each load. The outputs are three per-slot masks: request, remove and abort.

Top module: `fq_shadow_retire`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with no other input, `request_mask`, `remove_mask` and `abort_mask` are all zero. A reset applied to busy slots empties them.
- R2: `alloc_vld` with `alloc_idx` = k fills an empty slot k. Bit k of `request_mask` is high from the next cycle until the slot is issued.
- R3: A slot issued in cycle c outside any load shadow drops its request bit in cycle c+1. It raises its `remove_mask` bit for exactly cycle c+4 and is empty afterwards, whatever `load_hit` does.
- R4: The shadow is exactly the cycle after the one with `load_issue` high. A dependent slot issued two cycles after a load is removed at normal timing even if that load misses.
- R5: An independent slot issued in a shadow is removed in cycle c+4 and is never aborted, even if the load misses.
- R6: A dependent slot issued in a shadow of a load that hits shows no removal in cycle c+4 and is removed in cycle c+5.
- R7: A dependent slot issued in a shadow of a load that misses raises its `abort_mask` bit in cycle c+4, with its `request_mask` bit high and no removal. It keeps its slot and keeps requesting afterwards. At most one `abort_mask` bit is high in any cycle, and never together with the same slot's removal.
- R8: For a load with `load_issue` high in cycle L, `load_hit` is sampled only in cycle L+4 (1 = hit, 0 = miss). Its value in every other cycle has no effect.
- R9: An aborted slot that is issued again follows fresh timing for the new issue.
- R10: An issue aimed at a slot that is not requesting (empty or already issued) is ignored. Allocation aimed at a filled slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Fill the slot named by `alloc_idx` |
| alloc_idx | input | IDX_W | Slot to fill |
| issue_vld | input | 1 | The slot named by `issue_idx` is issued this cycle |
| issue_idx | input | IDX_W | Slot being issued |
| issue_dep | input | 1 | The issuing instruction consumes the most recent load's data |
| load_issue | input | 1 | A floating-point load issues this cycle |
| load_hit | input | 1 | Load outcome, sampled RES_LAT cycles after the load |
| request_mask | output | NUM_ENTRIES | Slots asking to be issued |
| remove_mask | output | NUM_ENTRIES | Slots leaving the queue this cycle |
| abort_mask | output | NUM_ENTRIES | Slots aborted this cycle |

## Verification
A slot with a wrong shadow or dependency flag shows up on `remove_mask` or `abort_mask` in the removal cycle, four or five cycles after the issue. A lost or misplaced hit sample swaps a late removal for an abort in that same cycle. A slot whose valid or issued state is wrong is visible on `request_mask` one cycle later, or as a missing or extra removal at c+4. The checks therefore sample every cycle around c+4 and c+5, so that a removal that comes one cycle early or late is not missed.

// File: rtl/lsqr_pkg.sv
package lsqr_pkg;

    // Width of the per-slot age counter; must hold NORM_LAT + 1.
    localparam int AGE_W = 4;

    // Per-slot bookkeeping carried through the queue.
    typedef struct packed {
        logic             valid;   // slot holds an instruction
        logic             issued;  // instruction is in flight
        logic             shadow;  // issued in the cycle after a load
        logic             dep;     // consumes that load's data
        logic             hit;     // captured load outcome
        logic [AGE_W-1:0] age;     // cycles since issue
    } slot_t;

    // What a slot does in the current cycle.
    typedef enum logic [1:0] {
        DISP_KEEP   = 2'd0,
        DISP_RETIRE = 2'd1,
        DISP_HOLD   = 2'd2,
        DISP_ABORT  = 2'd3
    } disp_e;

    // Decide the disposition of a slot from its state.
    function automatic disp_e classify(slot_t s, int norm_lat);
        logic spec_dep;
        disp_e d;
        spec_dep = s.shadow && s.dep;
        d = DISP_KEEP;
        if (s.valid && s.issued) begin
            if (s.age == AGE_W'(norm_lat)) begin
                if (!spec_dep)   d = DISP_RETIRE;
                else if (s.hit)  d = DISP_HOLD;
                else             d = DISP_ABORT;
            end else if (s.age == AGE_W'(norm_lat + 1)) begin
                if (spec_dep && s.hit) d = DISP_RETIRE;
            end
        end
        return d;
    endfunction

    // Saturating age increment.
    function automatic logic [AGE_W-1:0] age_step(logic [AGE_W-1:0] a);
        return (a == {AGE_W{1'b1}}) ? a : a + 1'b1;
    endfunction

endpackage

// File: rtl/lsqr_decode.sv
module lsqr_decode #(
    parameter int WIDTH = 8,
    localparam int SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [WIDTH-1:0] onehot
);
    always_comb begin
        onehot = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (en && (sel == SEL_W'(i))) onehot[i] = 1'b1;
        end
    end
endmodule

// File: rtl/lsqr_shadow_window.sv
module lsqr_shadow_window (
    input  logic clk,
    input  logic rst,
    input  logic load_issue,
    output logic window_open
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else     open_q <= load_issue;
    end

    assign window_open = open_q;

    // R4: the shadow never lasts two cycles unless a load issued in each
    assert_window_single_R4: assert property (@(posedge clk) disable iff (rst)
        (open_q && !load_issue) |=> !open_q);
endmodule

// File: rtl/lsqr_entry.sv
module lsqr_entry
    import lsqr_pkg::*;
#(
    parameter int NORM_LAT = 4,
    parameter int RES_LAT  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic alloc_sel,
    input  logic issue_sel,
    input  logic issue_shadow,
    input  logic issue_dep,
    input  logic load_hit,
    output logic request,
    output logic remove,
    output logic abort
);
    slot_t st_q, st_d;
    disp_e disp;
    logic  take_issue;

    always_comb begin
        disp    = classify(st_q, NORM_LAT);
        remove  = (disp == DISP_RETIRE);
        abort   = (disp == DISP_ABORT);
        request = st_q.valid && (!st_q.issued || abort);
        take_issue = issue_sel && request;
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.valid && alloc_sel) begin
            st_d       = '0;
            st_d.valid = 1'b1;
        end
        if (st_q.valid && st_q.issued) begin
            st_d.age = age_step(st_q.age);
            if (st_q.shadow && st_q.age == AGE_W'(RES_LAT - 1))
                st_d.hit = load_hit;
        end
        case (disp)
            DISP_RETIRE: st_d = '0;
            DISP_ABORT: begin
                st_d.issued = 1'b0;
                st_d.shadow = 1'b0;
                st_d.dep    = 1'b0;
                st_d.hit    = 1'b0;
                st_d.age    = '0;
            end
            default: ;
        endcase
        if (take_issue) begin
            st_d.issued = 1'b1;
            st_d.shadow = issue_shadow;
            st_d.dep    = issue_shadow && issue_dep;
            st_d.hit    = 1'b0;
            st_d.age    = AGE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R6: a held slot is removed in the following cycle
    assert_hold_then_remove_R6: assert property (@(posedge clk) disable iff (rst)
        (disp == DISP_HOLD) |=> remove);

    // R7: an aborted slot keeps its place and asks for issue again
    assert_abort_requeue_R7: assert property (@(posedge clk) disable iff (rst)
        (abort && !issue_sel) |=> (request && !st_q.issued));

    // R3: a removed slot stops requesting
    assert_remove_frees_R3: assert property (@(posedge clk) disable iff (rst)
        remove |=> !request);

    // R4: an issue outside a shadow never leaves a speculative dependency
    assert_normal_issue_R4: assert property (@(posedge clk) disable iff (rst)
        (take_issue && !issue_shadow) |=> (st_q.issued && !st_q.dep));

    // R10: an issue aimed at a slot already in flight changes nothing in its age
    assert_busy_issue_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (issue_sel && st_q.issued && disp == DISP_KEEP) |=> (st_q.age != AGE_W'(1)));
endmodule

// File: rtl/fq_shadow_retire.sv
module fq_shadow_retire
    import lsqr_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NORM_LAT    = 4,
    parameter int RES_LAT     = 4,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_vld,
    input  logic [IDX_W-1:0]       alloc_idx,
    input  logic                   issue_vld,
    input  logic [IDX_W-1:0]       issue_idx,
    input  logic                   issue_dep,
    input  logic                   load_issue,
    input  logic                   load_hit,
    output logic [NUM_ENTRIES-1:0] request_mask,
    output logic [NUM_ENTRIES-1:0] remove_mask,
    output logic [NUM_ENTRIES-1:0] abort_mask
);
    if (RES_LAT < 2 || RES_LAT > NORM_LAT || NORM_LAT + 1 >= (1 << AGE_W)) begin : g_bad_cfg
        $error("fq_shadow_retire: latency parameters out of range");
    end

    logic [NUM_ENTRIES-1:0] alloc_oh;
    logic [NUM_ENTRIES-1:0] issue_oh;
    logic                   in_shadow;

    lsqr_decode #(.WIDTH(NUM_ENTRIES)) u_alloc_dec (
        .en(alloc_vld), .sel(alloc_idx), .onehot(alloc_oh)
    );

    lsqr_decode #(.WIDTH(NUM_ENTRIES)) u_issue_dec (
        .en(issue_vld), .sel(issue_idx), .onehot(issue_oh)
    );

    lsqr_shadow_window u_window (
        .clk(clk), .rst(rst), .load_issue(load_issue), .window_open(in_shadow)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        lsqr_entry #(.NORM_LAT(NORM_LAT), .RES_LAT(RES_LAT)) u_slot (
            .clk          (clk),
            .rst          (rst),
            .alloc_sel    (alloc_oh[g]),
            .issue_sel    (issue_oh[g]),
            .issue_shadow (in_shadow),
            .issue_dep    (issue_dep),
            .load_hit     (load_hit),
            .request      (request_mask[g]),
            .remove       (remove_mask[g]),
            .abort        (abort_mask[g])
        );
    end

    // R7: only one slot can be aborted per cycle, since one issue per cycle
    assert_single_abort_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(abort_mask));

    // R7: no slot is removed and aborted together
    assert_no_remove_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (remove_mask & abort_mask) == '0);

    // R1: outputs are quiet the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (remove_mask == '0 && abort_mask == '0));
endmodule

// File: tb/tb_fq_shadow_retire.sv
module tb_fq_shadow_retire;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         alloc_vld = 1'b0, issue_vld = 1'b0, issue_dep = 1'b0;
    logic         load_issue = 1'b0, load_hit = 1'b0;
    logic [2:0]   alloc_idx = '0, issue_idx = '0;
    logic [N-1:0] request_mask, remove_mask, abort_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fq_shadow_retire dut (
        .clk(clk), .rst(rst),
        .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
        .issue_vld(issue_vld), .issue_idx(issue_idx), .issue_dep(issue_dep),
        .load_issue(load_issue), .load_hit(load_hit),
        .request_mask(request_mask), .remove_mask(remove_mask), .abort_mask(abort_mask)
    );

    typedef struct packed {
        logic       av; logic [2:0] ai;
        logic       iv; logic [2:0] ii; logic dep;
        logic       ld; logic hit;
        logic [7:0] rem; logic [7:0] abt; logic [7:0] req;
    } vec_t;

    // Expected masks hold at the start of the row; inputs are then applied for that row.
    localparam vec_t TABLE [14] = '{
        '{1'b1,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00,8'h00}, // R1 idle, fill 0
        '{1'b1,3'd1, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00,8'h01}, // R2
        '{1'b1,3'd2, 1'b0,3'd0,1'b0, 1'b1,1'b0, 8'h00,8'h00,8'h03}, // load L
        '{1'b0,3'd0, 1'b1,3'd0,1'b1, 1'b0,1'b0, 8'h00,8'h00,8'h07}, // slot0 in shadow, dep
        '{1'b0,3'd0, 1'b1,3'd1,1'b1, 1'b0,1'b0, 8'h00,8'h00,8'h06}, // slot1 at L+2 (R4)
        '{1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00,8'h04}, // R8 ignored
        '{1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b1, 8'h00,8'h00,8'h04}, // L+4 hit
        '{1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00,8'h04}, // R6 hold slot0
        '{1'b0,3'd0, 1'b1,3'd2,1'b0, 1'b0,1'b0, 8'h03,8'h00,8'h04}, // R6 slot0, R4 slot1
        '{1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00,8'h00},
        '{1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00,8'h00},
        '{1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00,8'h00},
        '{1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h04,8'h00,8'h00}, // R3 slot2
        '{1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0, 8'h00,8'h00,8'h00}
    };

    task automatic check(input logic [7:0] rem, input logic [7:0] abt,
                         input logic [7:0] req, input string tag);
        checks++;
        if (remove_mask !== rem || abort_mask !== abt || request_mask !== req) begin
            errors++;
            $display("FAIL %s: rem=%h abt=%h req=%h, expected rem=%h abt=%h req=%h",
                     tag, remove_mask, abort_mask, request_mask, rem, abt, req);
        end
    endtask

    task automatic drive(input logic av, input logic [2:0] ai, input logic iv,
                         input logic [2:0] ii, input logic dep, input logic ld,
                         input logic hit);
        alloc_vld = av; alloc_idx = ai; issue_vld = iv; issue_idx = ii;
        issue_dep = dep; load_issue = ld; load_hit = hit;
        @(negedge clk);
    endtask

    task automatic idle(input logic hit);
        drive(1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, hit);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(8'h00, 8'h00, 8'h00, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < 14; k++) begin
            check(TABLE[k].rem, TABLE[k].abt, TABLE[k].req,
                  $sformatf("R2/R3/R4/R6/R8 table row %0d", k));
            drive(TABLE[k].av, TABLE[k].ai, TABLE[k].iv, TABLE[k].ii,
                  TABLE[k].dep, TABLE[k].ld, TABLE[k].hit);
        end

        // Miss scenario: load at D2, slot3 dependent in shadow, slot6 dependent outside.
        check(8'h00, 8'h00, 8'h00, "R1 idle before D0");
        drive(1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);        // D0
        drive(1'b1, 3'd4, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);        // D1
        drive(1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1);        // D2 load
        check(8'h00, 8'h00, 8'h58, "R2 three fills");
        drive(1'b1, 3'd3, 1'b1, 3'd3, 1'b1, 1'b0, 1'b1);        // D3 slot3 shadow; refill slot3 ignored
        check(8'h00, 8'h00, 8'h50, "R10 fill of filled slot");
        drive(1'b0, 3'd0, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1);        // D4 slot6 at L+2
        drive(1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1);        // D5 reissue of busy slot3 ignored
        check(8'h00, 8'h00, 8'h10, "R10 busy slot issue");
        drive(1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);        // D6 L+4 miss
        check(8'h00, 8'h08, 8'h18, "R7 abort on miss (R8 other hits ignored)");
        idle(1'b1);                                              // D7
        check(8'h40, 8'h00, 8'h18, "R4 dependent outside shadow, R7 requeued");
        drive(1'b0, 3'd0, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0);        // D8 reissue slot3
        check(8'h00, 8'h00, 8'h10, "R9 reissued slot");
        drive(1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1);        // D9 second load
        drive(1'b0, 3'd0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1);        // D10 slot4 independent shadow
        check(8'h00, 8'h00, 8'h00, "R5 slot4 issued");
        drive(1'b0, 3'd0, 1'b1, 3'd5, 1'b0, 1'b0, 1'b1);        // D11 empty slot5 issue
        check(8'h08, 8'h00, 8'h00, "R9 fresh timing after abort");
        idle(1'b1);                                              // D12
        check(8'h00, 8'h00, 8'h00, "R8 before miss sample");
        idle(1'b0);                                              // D13 miss
        check(8'h10, 8'h00, 8'h00, "R5 independent shadow not aborted");
        idle(1'b0);                                              // D14
        check(8'h00, 8'h00, 8'h00, "R10 empty slot issue ignored");
        idle(1'b0);
        check(8'h00, 8'h00, 8'h00, "R10 empty slot never removed");

        // Reset with a busy slot.
        drive(1'b1, 3'd7, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 3'd0, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0);
        rst = 1'b1;
        idle(1'b0);
        rst = 1'b0;
        idle(1'b0);
        check(8'h00, 8'h00, 8'h00, "R1 reset empties busy slot");
        idle(1'b0);
        idle(1'b0);
        check(8'h00, 8'h00, 8'h00, "R1 no late removal after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule